// File: doc/BRIEF.md
# NMI Exception PC Register

This block is the machine-level control register that holds the resume address for a resumable non-maskable interrupt or a double trap. The trap controller pulses a capture strobe when such an event is taken. On that strobe the register loads the virtual PC of the instruction that was interrupted or that faulted. When the NMI-return instruction executes, the core reads the return-target output and uses it as the next PC. Apart from the capture strobe, hardware never changes the stored value.

Software reaches the register through a simple CSR port made of an address, a write enable, write data and read data. The block itself matches the address. Privilege checking is left to the surrounding pipeline. The stored value always has bit 0 cleared. Bit 1 is stored as written, but reads and the return target hide it while compressed instructions are disabled. The effective width switches at run time between 32 and 64 bits.

Top module: `nmpc_reg`

## Requirements
- R1: The block matches CSR address 0x741 only. When the address matches, `csr_hit_o` is 1 and `csr_rdata_o` carries the masked value. At any other address, `csr_hit_o` is 0, `csr_rdata_o` is 0, and a write leaves the stored value unchanged.
- R2: When `xlen64_i` is 0, bits 63:32 of both `csr_rdata_o` and `ret_pc_o` read as 0, even if the stored upper bits are nonzero. When `xlen64_i` is 1, all 64 stored bits are visible.
- R3: When `trap_take_i` is 1 at a clock edge, the register loads `trap_pc_i`. Bit 0 is cleared, and bits 63:32 are cleared if `xlen64_i` is 0.
- R4: Bit 0 of `csr_rdata_o` and of `ret_pc_o` is always 0. A software write stores bit 0 as 0.
- R5: When `cext_en_i` is 0, bit 1 of `csr_rdata_o` and of `ret_pc_o` reads as 0. The stored bit 1 is kept and becomes visible again once `cext_en_i` returns to 1.
- R6: A write (`csr_we_i`=1 with a matching address) stores `csr_wdata_i` at the next edge. Bit 0 is cleared, and bits 63:32 are cleared if `xlen64_i` is 0.
- R7: When a trap capture and a software write fall in the same cycle, the trap capture determines the stored value.
- R8: `ret_pc_o` always presents the stored value with the masks of R2, R4 and R5 applied. It does not depend on the CSR address.
- R9: After reset the stored value is 0.
- R10: With no capture and no matching write, the stored value holds across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | 12 | CSR address of the current access |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | Masked read data; 0 when the address does not match |
| csr_hit_o | output | 1 | High when the address matches this register |
| trap_take_i | input | 1 | Capture strobe from the trap controller |
| trap_pc_i | input | 64 | PC of the interrupted or faulting instruction |
| ret_pc_o | output | 64 | Masked jump target for the NMI-return instruction |
| xlen64_i | input | 1 | Width control: 0 selects 32-bit, 1 selects 64-bit |
| cext_en_i | input | 1 | Compressed-instruction enable |

## Verification
The temporal assertions assume that the width and compressed-enable controls change only in cycles where the check does not depend on them. For that reason, each property that compares values across an edge tests `$stable` on those controls, or the current control values, before it relates the outputs. The assertions also assume that `trap_take_i` and `csr_we_i` are clean levels at each edge. The stimulus drives every input only on falling edges and holds it for a full cycle. Between directed phases it toggles the width and enable controls so that the guarded and unguarded cases both occur.

// File: rtl/nmpc_pkg.sv
package nmpc_pkg;
    localparam int unsigned NMPC_XLEN   = 64;
    localparam int unsigned NMPC_LO_W   = 32;
    localparam int unsigned NMPC_ADDR_W = 12;

    typedef logic [NMPC_XLEN-1:0] nmpc_word_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_CSR  = 2'd1,
        SRC_TRAP = 2'd2
    } nmpc_src_e;

    typedef struct packed {
        nmpc_word_t pc;
    } nmpc_state_t;
endpackage

// File: rtl/nmpc_decode.sv
module nmpc_decode #(
    parameter int unsigned               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]         CSR_ADDR = 12'h741
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic              hit_o,
    output logic              wr_o
);
    always_comb begin
        hit_o = (addr_i == CSR_ADDR);
        wr_o  = hit_o & we_i;
    end
endmodule

// File: rtl/nmpc_next.sv
module nmpc_next
    import nmpc_pkg::*;
#(
    parameter int unsigned XLEN = NMPC_XLEN,
    parameter int unsigned LO_W = NMPC_LO_W
) (
    input  logic [XLEN-1:0] cur_i,
    input  logic            trap_i,
    input  logic [XLEN-1:0] trap_pc_i,
    input  logic            wr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            wide_i,
    output logic [XLEN-1:0] nxt_o
);
    nmpc_src_e       src;
    logic [XLEN-1:0] raw;

    always_comb begin
        // trap capture outranks a software write in the same cycle
        if (trap_i)    src = SRC_TRAP;
        else if (wr_i) src = SRC_CSR;
        else           src = SRC_HOLD;

        unique case (src)
            SRC_TRAP: raw = trap_pc_i;
            SRC_CSR:  raw = wdata_i;
            default:  raw = cur_i;
        endcase

        nxt_o = raw;
        if (src != SRC_HOLD) begin
            nxt_o[0] = 1'b0;
            if (!wide_i) nxt_o[XLEN-1:LO_W] = '0;
        end
    end
endmodule

// File: rtl/nmpc_view.sv
module nmpc_view #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned LO_W = 32
) (
    input  logic [XLEN-1:0] stored_i,
    input  logic            wide_i,
    input  logic            cext_i,
    output logic [XLEN-1:0] view_o
);
    logic [XLEN-1:0] lo_part;

    always_comb begin
        lo_part          = '0;
        lo_part[LO_W-1:0] = stored_i[LO_W-1:0];
        lo_part[1]       = stored_i[1] & cext_i;
        lo_part[0]       = 1'b0;
    end

    generate
        if (XLEN > LO_W) begin : g_wide
            always_comb begin
                view_o = lo_part;
                if (wide_i) view_o[XLEN-1:LO_W] = stored_i[XLEN-1:LO_W];
            end
        end else begin : g_narrow
            always_comb view_o = lo_part;
        end
    endgenerate
endmodule

// File: rtl/nmpc_reg.sv
module nmpc_reg
    import nmpc_pkg::*;
#(
    parameter int unsigned              XLEN     = NMPC_XLEN,
    parameter int unsigned              LO_W     = NMPC_LO_W,
    parameter int unsigned              ADDR_W   = NMPC_ADDR_W,
    parameter logic [ADDR_W-1:0]        CSR_ADDR = 12'h741
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_hit_o,
    input  logic              trap_take_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    output logic [XLEN-1:0]   ret_pc_o,
    input  logic              xlen64_i,
    input  logic              cext_en_i
);
    localparam logic [XLEN-1:0] BIT0_CLR = ~{{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] pc_d, pc_q;
    logic            hit, wr;
    logic [XLEN-1:0] view;

    nmpc_decode #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
        .addr_i (csr_addr_i),
        .we_i   (csr_we_i),
        .hit_o  (hit),
        .wr_o   (wr)
    );

    nmpc_next #(.XLEN(XLEN), .LO_W(LO_W)) u_next (
        .cur_i     (pc_q),
        .trap_i    (trap_take_i),
        .trap_pc_i (trap_pc_i),
        .wr_i      (wr),
        .wdata_i   (csr_wdata_i),
        .wide_i    (xlen64_i),
        .nxt_o     (pc_d)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pc_q <= '0;
        else         pc_q <= pc_d;
    end

    nmpc_view #(.XLEN(XLEN), .LO_W(LO_W)) u_view (
        .stored_i (pc_q),
        .wide_i   (xlen64_i),
        .cext_i   (cext_en_i),
        .view_o   (view)
    );

    always_comb begin
        csr_hit_o   = hit;
        csr_rdata_o = hit ? view : '0;
        ret_pc_o    = view;
    end

    p_bit0_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_pc_o[0] == 1'b0) && (csr_rdata_o[0] == 1'b0));

    p_upper_hidden_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xlen64_i |-> (ret_pc_o[XLEN-1:LO_W] == '0));

    p_bit1_hidden_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cext_en_i |-> (ret_pc_o[1] == 1'b0));

    p_miss_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i != CSR_ADDR) |-> (csr_rdata_o == '0));

    p_trap_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_take_i && xlen64_i) |=>
            (!(xlen64_i && cext_en_i) || ret_pc_o == ($past(trap_pc_i) & BIT0_CLR)));

    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_take_i && !(csr_we_i && csr_addr_i == CSR_ADDR)) |=>
            (!($stable(xlen64_i) && $stable(cext_en_i)) || $stable(ret_pc_o)));

    p_rd_matches_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_hit_o |-> (csr_rdata_o == ret_pc_o));
endmodule

// File: tb/nmpc_reg_tb_top.sv
module nmpc_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] addr;
    logic        we;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic        hit;
    logic        trap;
    logic [63:0] tpc;
    logic [63:0] ret;
    logic        x64;
    logic        cext;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [63:0] ref_v = 64'd0;

    always #4 clk = ~clk;

    nmpc_reg dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .csr_addr_i  (addr),
        .csr_we_i    (we),
        .csr_wdata_i (wdata),
        .csr_rdata_o (rdata),
        .csr_hit_o   (hit),
        .trap_take_i (trap),
        .trap_pc_i   (tpc),
        .ret_pc_o    (ret),
        .xlen64_i    (x64),
        .cext_en_i   (cext)
    );

    function automatic logic [63:0] masked(logic [63:0] v, logic w, logic c);
        logic [63:0] r;
        r = v;
        if (!w) r = {32'd0, v[31:0]};
        r[0] = 1'b0;
        if (!c) r[1] = 1'b0;
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [11:0] a, logic w, logic [63:0] wd,
                        logic t, logic [63:0] tp, logic wide, logic c);
        logic [63:0] nv;
        logic        h;
        @(negedge clk);
        addr = a; we = w; wdata = wd; trap = t; tpc = tp; x64 = wide; cext = c;
        #1;
        h = (a == 12'h741);
        chk({tag, " R1 hit"}, {63'd0, hit}, {63'd0, h});
        chk({tag, " R1 R2 R4 R5 read"}, rdata, h ? masked(ref_v, wide, c) : 64'd0);
        chk({tag, " R8 ret"}, ret, masked(ref_v, wide, c));
        @(posedge clk);
        nv = ref_v;
        if (t)           nv = tp;
        else if (w && h) nv = wd;
        if (t || (w && h)) begin
            nv[0] = 1'b0;
            if (!wide) nv[63:32] = 32'd0;
        end
        ref_v = nv;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = 12'h741; we = 1'b0; wdata = '0; trap = 1'b0;
        tpc = '0; x64 = 1'b1; cext = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9 reset value
        step("R9 reset", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R6 R4 64-bit write, odd data
        step("R6 write", 12'h741, 1, 64'hDEAD_BEEF_1234_5677, 0, 64'h0, 1, 1);
        step("R4 R6 readback", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R5 bit1 hidden then restored
        step("R5 hide", 12'h741, 0, 64'h0, 0, 64'h0, 1, 0);
        step("R5 store hidden", 12'h741, 1, 64'h0000_0000_0000_00F2, 0, 64'h0, 1, 0);
        step("R5 still hidden", 12'h741, 0, 64'h0, 0, 64'h0, 1, 0);
        step("R5 restored", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R2 width switching
        step("R6 wide write", 12'h741, 1, 64'hAAAA_5555_0000_1006, 0, 64'h0, 1, 1);
        step("R2 narrow view", 12'h741, 0, 64'h0, 0, 64'h0, 0, 1);
        step("R2 wide again", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        step("R6 narrow write", 12'h741, 1, 64'hFFFF_FFFF_8000_0003, 0, 64'h0, 0, 1);
        step("R2 R6 upper cleared", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R1 other address ignored
        step("R1 miss write", 12'h340, 1, 64'h1111_2222_3333_4444, 0, 64'h0, 1, 1);
        step("R1 unchanged", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R3 trap capture, R7 trap over write
        step("R3 trap", 12'h000, 0, 64'h0, 1, 64'h8000_0000_0040_0107, 1, 1);
        step("R3 captured", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        step("R7 collide", 12'h741, 1, 64'h5555_5555_5555_5554, 1, 64'h0123_4567_89AB_CDEE, 1, 1);
        step("R7 trap won", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        step("R3 narrow trap", 12'h741, 0, 64'h0, 1, 64'hFEED_0000_0000_2222, 0, 0);
        step("R3 narrow seen", 12'h741, 0, 64'h0, 0, 64'h0, 1, 1);
        // R10 idle hold
        for (int i = 0; i < 6; i++)
            step("R10 hold", (i % 2) ? 12'h741 : 12'h7C0, 0, 64'h0, 0, 64'h0, 1, 1);
        // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            a = ($urandom % 3 == 0) ? 12'h741 : 12'($urandom);
            step("R1 R3 R6 R7 mixed", a, 1'($urandom % 2), {$urandom, $urandom},
                 1'($urandom % 5 == 0), {$urandom, $urandom},
                 1'($urandom % 2), 1'($urandom % 2));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule